// File: doc/BRIEF.md
# Debug Address-Compare Interrupt Unit

This unit gives a 32-bit core hardware breakpoints on instruction fetch. It has a set of instruction address compare registers. Each one can be turned on by its own enable bit. When an enabled register matches the effective address of a valid fetch, the unit sets that comparator's bit in a sticky debug status register. Address bits 1:0 are not compared. The comparison uses the effective address as presented, with no translation.

Pending status bits raise a critical-class debug interrupt request, but only while the debug-enable bit of the machine state is 1. The critical-enable bit has no say in this. The unit holds the machine state register and a dedicated pair of critical save/restore registers:
- A take strobe saves the return PC and the machine state into the critical pair, then clears the enable bits.
- A return-from-critical strobe reloads the machine state from the pair and presents the saved PC as the resume address.
- The ordinary return-from-interrupt strobe leaves the critical pair alone.

All registers sit behind a supervisor-only special-purpose-register port, decoded by SPR number.

Top module: `dbg_cmp_unit`

## Requirements
- R1: Control SPR 308 holds one enable per comparator (bit 0 enables compare 1, bit 1 enables compare 2). An enabled comparator whose register (SPR 312 for compare 1, SPR 313 for compare 2) equals a valid fetch address in bits 31:2 sets status bit 0 or bit 1 respectively at the next clock. A disabled comparator, or a fetch with valid low, sets nothing. Compare registers read back with bits 1:0 zero.
- R2: Status bits are sticky. Writing SPR 304 clears each status bit whose write-data bit is 1 and keeps all others. Software can never set a status bit.
- R3: `dbg_req_o` is 1 exactly when machine-state bit 9 (debug enable) is 1 and at least one status bit is set. Machine-state bit 17 (critical enable) has no effect. A status bit already pending raises the request in the same cycle debug enable turns on.
- R4: On `take_i`, CSRR0 (SPR 58) takes `take_pc_i` and CSRR1 (SPR 59) takes the current machine state. Machine-state bits 9 and 17 are then cleared, so `dbg_req_o` is 0 in the following cycle.
- R5: On `rfci_i`, the machine state is reloaded from CSRR1. `resume_pc_o` always shows CSRR0. The priority order is `take_i`, then `rfci_i`, then `msr_we_i`. A take also blocks SPR writes to CSRR0 and CSRR1 in the same cycle.
- R6: `rfi_i` leaves CSRR0, CSRR1 and the machine state unchanged.
- R7: SPR 415 is the debug vector offset, and it reads back with bits 3:0 zero. SPR 314 and 315 are unimplemented compare slots: they read as zero and ignore writes. Any unmapped number also reads as zero.
- R8: An access with `spr_super_i` low changes no state and reads zero. It raises `priv_fault_o` combinationally in the same cycle.
- R9: `dbg_vec_o` equals the offset register with bits 3:0 forced to zero.
- R10: After reset, every register and output is zero.
- R11: A comparator match sets its status bit even when a clear of the same bit arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spr_valid_i | input | 1 | SPR access strobe |
| spr_we_i | input | 1 | 1 = write, 0 = read |
| spr_super_i | input | 1 | Access is made in supervisor mode |
| spr_addr_i | input | 10 | SPR number |
| spr_wdata_i | input | 32 | SPR write data |
| spr_rdata_o | output | 32 | SPR read data, combinational |
| priv_fault_o | output | 1 | Access attempted without supervisor mode |
| fetch_valid_i | input | 1 | Fetch address valid |
| fetch_ea_i | input | 32 | Fetch effective address |
| msr_we_i | input | 1 | Load the machine state |
| msr_wdata_i | input | 32 | New machine state |
| msr_o | output | 32 | Current machine state |
| take_i | input | 1 | Debug interrupt taken |
| take_pc_i | input | 32 | Return address to save |
| rfci_i | input | 1 | Return from critical interrupt |
| rfi_i | input | 1 | Ordinary return from interrupt |
| dbg_req_o | output | 1 | Debug interrupt request |
| dbg_vec_o | output | 32 | Debug vector offset |
| resume_pc_o | output | 32 | Resume address (CSRR0) |

## Verification
The bench builds the unit with its default parameters: two comparators, a 32-bit datapath and two ignored low address bits. With two comparators it can drive both status bits independently, fill one while the other is disabled, and clear them selectively. The ignored-bit setting lets fetch addresses that differ only in bits 1:0 be shown to match. It also shows that a one-word difference does not match. The two reserved compare numbers fall just above the implemented range, so their read-as-zero behaviour is exercised directly.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned SPR_W = 10;
  localparam logic [SPR_W-1:0] SPR_STS      = 10'd304;
  localparam logic [SPR_W-1:0] SPR_CTRL     = 10'd308;
  localparam logic [SPR_W-1:0] SPR_CMP_BASE = 10'd312;
  localparam logic [SPR_W-1:0] SPR_IVO      = 10'd415;
  localparam logic [SPR_W-1:0] SPR_CSRR0    = 10'd58;
  localparam logic [SPR_W-1:0] SPR_CSRR1    = 10'd59;
  localparam int unsigned MSR_DE = 9;
  localparam int unsigned MSR_CE = 17;
  localparam int unsigned VEC_ALIGN = 4;
endpackage

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IGN  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            en_i,
  input  logic            fetch_vld_i,
  input  logic [XLEN-1:0] fetch_ea_i,
  output logic [XLEN-1:0] val_o,
  output logic            hit_o
);
  logic [XLEN-1:IGN] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= '0;
    else if (wr_i) cmp_q <= wdata_i[XLEN-1:IGN];
  end

  assign val_o = {cmp_q, {IGN{1'b0}}};
  assign hit_o = en_i && fetch_vld_i && (fetch_ea_i[XLEN-1:IGN] == cmp_q);
endmodule

// File: rtl/dbg_status.sv
module dbg_status #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;
  logic [N-1:0] clr_m;

  assign clr_m = clr_we_i ? clr_i : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_m) | set_i;
  end

  assign sts_o = sts_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_q[i] && !clr_m[i]) |=> sts_q[i]);
    a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> sts_q[i]);
    a_r2_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sts_q[i] && !set_i[i]) |=> !sts_q[i]);
  end
endmodule

// File: rtl/dbg_crit_save.sv
module dbg_crit_save
  import dbg_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [XLEN-1:0] take_pc_i,
  input  logic            rfci_i,
  input  logic            msr_we_i,
  input  logic [XLEN-1:0] msr_wdata_i,
  input  logic            csrr0_we_i,
  input  logic            csrr1_we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] csrr0_o,
  output logic [XLEN-1:0] csrr1_o
);
  logic [XLEN-1:0] msr_q, csrr0_q, csrr1_q;
  logic [XLEN-1:0] take_mask;

  always_comb begin
    take_mask = '1;
    take_mask[MSR_DE] = 1'b0;
    take_mask[MSR_CE] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msr_q   <= '0;
      csrr0_q <= '0;
      csrr1_q <= '0;
    end else if (take_i) begin
      csrr0_q <= take_pc_i;
      csrr1_q <= msr_q;
      msr_q   <= msr_q & take_mask;
    end else begin
      if (rfci_i)        msr_q <= csrr1_q;
      else if (msr_we_i) msr_q <= msr_wdata_i;
      if (csrr0_we_i) csrr0_q <= wdata_i;
      if (csrr1_we_i) csrr1_q <= wdata_i;
    end
  end

  assign msr_o   = msr_q;
  assign csrr0_o = csrr0_q;
  assign csrr1_o = csrr1_q;

  a_r4_take_saves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (csrr1_q == $past(msr_q)) && (csrr0_q == $past(take_pc_i)) && !msr_q[MSR_DE]);
  a_r5_rfci_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfci_i && !take_i) |=> msr_q == $past(csrr1_q));
endmodule

// File: rtl/dbg_cmp_unit.sv
module dbg_cmp_unit
  import dbg_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NUM_CMP = 2,
  parameter int unsigned IGN     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spr_valid_i,
  input  logic             spr_we_i,
  input  logic             spr_super_i,
  input  logic [SPR_W-1:0] spr_addr_i,
  input  logic [XLEN-1:0]  spr_wdata_i,
  output logic [XLEN-1:0]  spr_rdata_o,
  output logic             priv_fault_o,
  input  logic             fetch_valid_i,
  input  logic [XLEN-1:0]  fetch_ea_i,
  input  logic             msr_we_i,
  input  logic [XLEN-1:0]  msr_wdata_i,
  output logic [XLEN-1:0]  msr_o,
  input  logic             take_i,
  input  logic [XLEN-1:0]  take_pc_i,
  input  logic             rfci_i,
  input  logic             rfi_i,
  output logic             dbg_req_o,
  output logic [XLEN-1:0]  dbg_vec_o,
  output logic [XLEN-1:0]  resume_pc_o
);
  logic                spr_ok, spr_wr;
  logic [NUM_CMP-1:0]  ctrl_q, hit, sts;
  logic [XLEN-1:0]     cmp_val [NUM_CMP];
  logic [XLEN-1:VEC_ALIGN] ivo_q;
  logic [XLEN-1:0]     csrr0, csrr1, msr;

  assign spr_ok       = spr_valid_i && spr_super_i;
  assign spr_wr       = spr_ok && spr_we_i;
  assign priv_fault_o = spr_valid_i && !spr_super_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ivo_q  <= '0;
    end else begin
      if (spr_wr && spr_addr_i == SPR_CTRL) ctrl_q <= spr_wdata_i[NUM_CMP-1:0];
      if (spr_wr && spr_addr_i == SPR_IVO)  ivo_q  <= spr_wdata_i[XLEN-1:VEC_ALIGN];
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    dbg_addr_cmp #(.XLEN(XLEN), .IGN(IGN)) u_cmp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (spr_wr && spr_addr_i == SPR_CMP_BASE + SPR_W'(i)),
      .wdata_i    (spr_wdata_i),
      .en_i       (ctrl_q[i]),
      .fetch_vld_i(fetch_valid_i),
      .fetch_ea_i (fetch_ea_i),
      .val_o      (cmp_val[i]),
      .hit_o      (hit[i])
    );
  end

  dbg_status #(.N(NUM_CMP)) u_sts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (hit),
    .clr_we_i(spr_wr && spr_addr_i == SPR_STS),
    .clr_i   (spr_wdata_i[NUM_CMP-1:0]),
    .sts_o   (sts)
  );

  dbg_crit_save #(.XLEN(XLEN)) u_crit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take_i),
    .take_pc_i  (take_pc_i),
    .rfci_i     (rfci_i),
    .msr_we_i   (msr_we_i),
    .msr_wdata_i(msr_wdata_i),
    .csrr0_we_i (spr_wr && spr_addr_i == SPR_CSRR0),
    .csrr1_we_i (spr_wr && spr_addr_i == SPR_CSRR1),
    .wdata_i    (spr_wdata_i),
    .msr_o      (msr),
    .csrr0_o    (csrr0),
    .csrr1_o    (csrr1)
  );

  always_comb begin
    spr_rdata_o = '0;
    if (spr_ok) begin
      unique case (spr_addr_i)
        SPR_STS:   spr_rdata_o = XLEN'(sts);
        SPR_CTRL:  spr_rdata_o = XLEN'(ctrl_q);
        SPR_IVO:   spr_rdata_o = {ivo_q, {VEC_ALIGN{1'b0}}};
        SPR_CSRR0: spr_rdata_o = csrr0;
        SPR_CSRR1: spr_rdata_o = csrr1;
        default: begin
          for (int i = 0; i < NUM_CMP; i++)
            if (spr_addr_i == SPR_CMP_BASE + SPR_W'(i)) spr_rdata_o = cmp_val[i];
        end
      endcase
    end
  end

  // critical-enable deliberately not part of the gate
  assign dbg_req_o   = msr[MSR_DE] && (|sts);
  assign dbg_vec_o   = {ivo_q, {VEC_ALIGN{1'b0}}};
  assign msr_o       = msr;
  assign resume_pc_o = csrr0;

  a_r4_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !dbg_req_o);
  a_r6_rfi_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfi_i && !take_i && !spr_wr) |=> $stable(csrr0) && $stable(csrr1));
  a_r8_user_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_valid_i && !spr_super_i) |=> $stable(ctrl_q) && $stable(ivo_q) && $stable(sts));
  a_r8_user_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_fault_o |-> spr_rdata_o == '0);
endmodule

// File: tb/tb_dbg_cmp_unit.sv
module tb_dbg_cmp_unit;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        spr_valid = 0, spr_we = 0, spr_super = 0;
  logic [9:0]  spr_addr = 0;
  logic [31:0] spr_wdata = 0, spr_rdata;
  logic        priv_fault;
  logic        fetch_valid = 0;
  logic [31:0] fetch_ea = 0;
  logic        msr_we = 0;
  logic [31:0] msr_wdata = 0, msr;
  logic        take = 0, rfci = 0, rfi = 0;
  logic [31:0] take_pc = 0;
  logic        dbg_req;
  logic [31:0] dbg_vec, resume_pc;

  dbg_cmp_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .spr_valid_i(spr_valid), .spr_we_i(spr_we), .spr_super_i(spr_super),
    .spr_addr_i(spr_addr), .spr_wdata_i(spr_wdata), .spr_rdata_o(spr_rdata),
    .priv_fault_o(priv_fault),
    .fetch_valid_i(fetch_valid), .fetch_ea_i(fetch_ea),
    .msr_we_i(msr_we), .msr_wdata_i(msr_wdata), .msr_o(msr),
    .take_i(take), .take_pc_i(take_pc), .rfci_i(rfci), .rfi_i(rfi),
    .dbg_req_o(dbg_req), .dbg_vec_o(dbg_vec), .resume_pc_o(resume_pc)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  localparam logic [31:0] DE = 32'h200, CE = 32'h20000;

  // reference model state
  logic [31:0] m_msr = 0, m_c0 = 0, m_c1 = 0, m_ivo = 0;
  logic [31:0] m_cmp [2] = '{0, 0};
  logic [1:0]  m_en = 0, m_sts = 0;

  function automatic logic [31:0] m_read(logic [9:0] a);
    if (!(spr_valid && spr_super)) return 0;
    case (a)
      304: return {30'd0, m_sts};
      308: return {30'd0, m_en};
      312: return m_cmp[0];
      313: return m_cmp[1];
      415: return m_ivo;
      58:  return m_c0;
      59:  return m_c1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) if (rst_n) begin
    logic [1:0] hits, clr;
    logic wr;
    wr = spr_valid && spr_super && spr_we;
    for (int i = 0; i < 2; i++)
      hits[i] = m_en[i] && fetch_valid && (fetch_ea[31:2] == m_cmp[i][31:2]);
    clr = (wr && spr_addr == 304) ? spr_wdata[1:0] : 2'b00;
    m_sts = (m_sts & ~clr) | hits;
    if (wr && spr_addr == 308) m_en = spr_wdata[1:0];
    if (wr && spr_addr == 312) m_cmp[0] = spr_wdata & 32'hFFFF_FFFC;
    if (wr && spr_addr == 313) m_cmp[1] = spr_wdata & 32'hFFFF_FFFC;
    if (wr && spr_addr == 415) m_ivo = spr_wdata & 32'hFFFF_FFF0;
    if (take) begin
      m_c0 = take_pc; m_c1 = m_msr; m_msr = m_msr & ~(DE | CE);
    end else begin
      if (rfci) m_msr = m_c1;
      else if (msr_we) m_msr = msr_wdata;
      if (wr && spr_addr == 58) m_c0 = spr_wdata;
      if (wr && spr_addr == 59) m_c1 = spr_wdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 dbg_req", {31'd0, dbg_req}, {31'd0, m_msr[9] && (|m_sts)});
    chk("R9 dbg_vec", dbg_vec, m_ivo);
    chk("R4/R5 msr", msr, m_msr);
    chk("R5 resume_pc", resume_pc, m_c0);
    chk("R8 priv_fault", {31'd0, priv_fault}, {31'd0, spr_valid && !spr_super});
  end

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
    spr_valid = 0; spr_we = 0; fetch_valid = 0; msr_we = 0;
    take = 0; rfci = 0; rfi = 0;
  endtask

  task automatic wr_spr(logic [9:0] a, logic [31:0] d, logic sup = 1);
    spr_valid = 1; spr_we = 1; spr_super = sup; spr_addr = a; spr_wdata = d;
    step();
  endtask

  task automatic rd_spr(logic [9:0] a, logic [31:0] exp, string tag, logic sup = 1);
    spr_valid = 1; spr_we = 0; spr_super = sup; spr_addr = a;
    #1;
    chk(tag, spr_rdata, exp);
    chk({tag, " model"}, spr_rdata, m_read(a));
    step();
  endtask

  task automatic fetch(logic [31:0] ea);
    fetch_valid = 1; fetch_ea = ea; step();
  endtask

  task automatic set_msr(logic [31:0] v);
    msr_we = 1; msr_wdata = v; step();
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R10 reset state
    chk("R10 req", {31'd0, dbg_req}, 0);
    chk("R10 msr", msr, 0);
    rd_spr(304, 0, "R10 status");
    rd_spr(312, 0, "R10 cmp1");
    rd_spr(59, 0, "R10 csrr1");

    // R1 compare and enable
    wr_spr(308, 3);
    wr_spr(312, 32'h0000_1003);
    wr_spr(313, 32'h0000_2004);
    rd_spr(312, 32'h0000_1000, "R1 cmp1 readback");
    fetch_valid = 0; fetch_ea = 32'h1000; step();
    rd_spr(304, 0, "R1 invalid fetch");
    fetch(32'h0000_1003);
    rd_spr(304, 1, "R1 cmp1 hit");
    fetch(32'h0000_2000);
    rd_spr(304, 1, "R1 near miss");
    fetch(32'h0000_2007);
    rd_spr(304, 3, "R1 cmp2 hit");

    // R2 clear by ones, never set
    wr_spr(304, 1);
    rd_spr(304, 2, "R2 clear bit0");
    wr_spr(308, 2);
    fetch(32'h0000_1000);
    rd_spr(304, 2, "R1 disabled cmp");
    wr_spr(304, 32'hFFFF_FFFC);
    rd_spr(304, 2, "R2 no set");

    // R3 gating
    set_msr(CE);
    chk("R3 CE alone", {31'd0, dbg_req}, 0);
    set_msr(DE | 32'h1);
    chk("R3 DE pending", {31'd0, dbg_req}, 1);

    // R9 vector
    wr_spr(415, 32'h1234_5678);
    chk("R9 vec", dbg_vec, 32'h1234_5670);
    rd_spr(415, 32'h1234_5670, "R7 ivo readback");

    // R4 take
    take = 1; take_pc = 32'hABCD_0000; step();
    chk("R4 req dropped", {31'd0, dbg_req}, 0);
    chk("R4 msr cleared", msr, 32'h1);
    rd_spr(58, 32'hABCD_0000, "R4 csrr0");
    rd_spr(59, DE | 32'h1, "R4 csrr1");

    // R6 rfi leaves critical pair
    rfi = 1; step();
    rd_spr(58, 32'hABCD_0000, "R6 csrr0");
    rd_spr(59, DE | 32'h1, "R6 csrr1");
    chk("R6 msr", msr, 32'h1);

    // R5 rfci
    rfci = 1; msr_we = 1; msr_wdata = 32'hDEAD; step();
    chk("R5 msr restored", msr, DE | 32'h1);
    chk("R5 resume", resume_pc, 32'hABCD_0000);
    chk("R3 req again", {31'd0, dbg_req}, 1);

    // R5 take beats SPR write to csrr0
    spr_valid = 1; spr_we = 1; spr_super = 1; spr_addr = 58; spr_wdata = 32'h5555;
    take = 1; take_pc = 32'h0000_4444; step();
    rd_spr(58, 32'h0000_4444, "R5 take over csrr write");
    wr_spr(58, 32'h7777_0000);
    rd_spr(58, 32'h7777_0000, "R7 csrr0 write");

    // R7 reserved
    wr_spr(314, 32'hFFFF_FFFF);
    rd_spr(314, 0, "R7 slot 314");
    rd_spr(315, 0, "R7 slot 315");
    rd_spr(500, 0, "R7 unmapped");

    // R8 user access
    wr_spr(304, 32'hFFFF_FFFF, 0);
    wr_spr(415, 0, 0);
    rd_spr(304, 0, "R8 user read", 0);
    rd_spr(304, 2, "R8 status kept");
    chk("R8 vec kept", dbg_vec, 32'h1234_5670);

    // R11 set wins over clear
    wr_spr(308, 3);
    spr_valid = 1; spr_we = 1; spr_super = 1; spr_addr = 304; spr_wdata = 3;
    fetch_valid = 1; fetch_ea = 32'h0000_1001; step();
    rd_spr(304, 1, "R11 set wins");

    repeat (2) step();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule